// File: doc/BRIEF.md
# Multi-Phase Spreading-Code Correlator Bank

This block searches for the code phase of a known binary spreading sequence in a stream of signed samples. A bank of correlators runs in parallel on the same samples. Each one is tied to a fixed code offset and adds or subtracts every sample according to its own rotated copy of the code. Because all offsets are tested in one code period, throughput is kept at a low clock rate. This suits acquisition at a reduced supply voltage.

Samples arrive with a valid strobe and pass through a single capture register, which broadcasts them to every correlator. After a full code period of valid samples, a peak picker takes the magnitude of every accumulator. It finds the largest one, choosing the lowest offset on a tie, and compares it with a threshold. If the peak clears the threshold, it raises a one-cycle detect pulse with the winning offset and the peak magnitude. The next period then starts from fresh sums.

A clear input abandons the period in progress. A code-load input installs a new code word and also restarts the period.

Top module: `pn_corr_bank`

## Requirements
- R1: After reset, det_valid is 0, and det_pos and det_peak are 0.
- R2: Samples are two's complement with SAMPLE_W bits. Bit j of code_word is chip j. A chip of 1 adds the sample to a correlator sum and a chip of 0 subtracts it.
- R3: For the n-th valid sample of a period (n counted from 0), correlator k uses chip (n + k) mod CODE_LEN.
- R4: Cycles with samp_valid low do not advance the period and do not change any sum, whatever samp_data holds.
- R5: A period ends with its CODE_LEN-th valid sample. If that sample is captured at clock edge t, any detection shows on det_valid for exactly the one cycle after edge t+2.
- R6: det_peak is the largest absolute sum in the bank. det_pos is the lowest correlator index that has that magnitude.
- R7: A detection is reported only when the peak is greater than or equal to thresh. Otherwise det_valid stays 0 for that period.
- R8: Between detections, det_pos and det_peak keep their last reported values.
- R9: clear discards the period in progress. A sample presented together with clear is dropped, and the next valid sample is sample 0 of a new period.
- R10: code_load replaces the code with code_word and restarts the period in the same way as clear.
- R11: Back-to-back periods with no idle cycle are each correlated and reported separately.
- R12: Sums reach the extremes of CODE_LEN times the largest sample magnitude (for example ±496 with the defaults) without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_load | input | 1 | Load code_word and restart the period |
| code_word | input | CODE_LEN | Spreading code, bit j is chip j |
| clear | input | 1 | Abandon the current period |
| samp_valid | input | 1 | samp_data holds a sample this cycle |
| samp_data | input | SAMPLE_W | Signed input sample |
| thresh | input | ACC_W | Detection threshold on the peak magnitude |
| det_valid | output | 1 | One-cycle detection pulse |
| det_pos | output | POS_W | Winning correlator offset |
| det_peak | output | ACC_W | Magnitude of the winning sum |

## Verification
The bench drives sample streams built to match the code at a chosen offset. A correct chip rotation yields the right winner, while a wrong rotation or a wrong sign moves det_pos or changes det_peak. An all-zero stream and an all-ones code with the most negative sample create ties across the whole bank. These expose any tie-break that is not the lowest index, and any sum that wraps at the extreme. Further streams with gaps holding junk data, a clear or a code load in mid-period, back-to-back periods, and a threshold just above or exactly at the peak separate the period counting and gating from the arithmetic.

// File: rtl/pncb_pkg.sv
package pncb_pkg;

  // Signed sum width: one sample width plus enough bits for CODE_LEN terms.
  function automatic int acc_width(input int sample_w, input int code_len);
    return sample_w + $clog2(code_len);
  endfunction

  function automatic int pos_width(input int num_corr);
    return (num_corr > 1) ? $clog2(num_corr) : 1;
  endfunction

  // Chip index for a given phase and correlator offset, modulo the code length.
  function automatic int wrap_phase(input int phase, input int offset, input int code_len);
    int s;
    s = phase + offset;
    if (s >= code_len) s = s - code_len;
    return s;
  endfunction

endpackage

// File: rtl/pncb_ingest.sv
module pncb_ingest #(
  parameter int CODE_LEN = 31,
  parameter int SAMPLE_W = 5,
  localparam int IDX_W = $clog2(CODE_LEN)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clear,
  input  logic                       code_load,
  input  logic [CODE_LEN-1:0]        code_word,
  input  logic                       samp_valid,
  input  logic signed [SAMPLE_W-1:0] samp_data,
  output logic [CODE_LEN-1:0]        code_q,
  output logic                       stg_valid,
  output logic signed [SAMPLE_W-1:0] stg_data,
  output logic [IDX_W-1:0]           stg_idx,
  output logic                       stg_first,
  output logic                       stg_last
);

  logic [IDX_W-1:0] phase_q;
  logic             restart;
  logic             at_end;

  assign restart = clear | code_load;
  assign at_end  = (phase_q == IDX_W'(CODE_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= '0;
      code_q    <= '0;
      stg_valid <= 1'b0;
      stg_data  <= '0;
      stg_idx   <= '0;
    end else begin
      if (code_load) code_q <= code_word;
      stg_valid <= samp_valid & ~restart;
      if (restart) begin
        phase_q <= '0;
      end else if (samp_valid) begin
        phase_q <= at_end ? '0 : phase_q + 1'b1;
      end
      if (samp_valid) begin
        stg_data <= samp_data;
        stg_idx  <= phase_q;
      end
    end
  end

  assign stg_first = (stg_idx == '0);
  assign stg_last  = (stg_idx == IDX_W'(CODE_LEN - 1));

endmodule

// File: rtl/pncb_lane.sv
module pncb_lane
  import pncb_pkg::*;
#(
  parameter int CODE_LEN = 31,
  parameter int SAMPLE_W = 5,
  parameter int ACC_W    = 10,
  parameter int OFFSET   = 0,
  localparam int IDX_W = $clog2(CODE_LEN)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic                       first,
  input  logic [IDX_W-1:0]           idx,
  input  logic [CODE_LEN-1:0]        code,
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic signed [ACC_W-1:0]    acc
);

  logic [IDX_W-1:0]        sel;
  logic                    chip;
  logic signed [ACC_W-1:0] ext;
  logic signed [ACC_W-1:0] term;

  always_comb begin
    sel  = IDX_W'(wrap_phase(int'(idx), OFFSET, CODE_LEN));
    chip = code[sel];
    ext  = {{(ACC_W - SAMPLE_W){sample[SAMPLE_W-1]}}, sample};
    term = chip ? ext : -ext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (en) begin
      acc <= first ? term : acc + term;
    end
  end

endmodule

// File: rtl/pncb_peak.sv
module pncb_peak #(
  parameter int NUM_CORR = 8,
  parameter int ACC_W    = 10,
  parameter int POS_W    = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      fin,
  input  logic [ACC_W-1:0]          thresh,
  input  logic [NUM_CORR*ACC_W-1:0] acc_flat,
  output logic                      det_valid,
  output logic [POS_W-1:0]          det_pos,
  output logic [ACC_W-1:0]          det_peak
);

  logic [ACC_W-1:0] mag [NUM_CORR];
  logic [ACC_W-1:0] best_mag;
  logic [POS_W-1:0] best_pos;
  logic             hit;

  always_comb begin
    for (int k = 0; k < NUM_CORR; k++) begin
      logic signed [ACC_W-1:0] a;
      a      = acc_flat[k*ACC_W +: ACC_W];
      mag[k] = a[ACC_W-1] ? ACC_W'(-a) : ACC_W'(a);
    end
  end

  // Linear scan with strict compare keeps the lowest index on ties.
  always_comb begin
    best_mag = mag[0];
    best_pos = '0;
    for (int k = 1; k < NUM_CORR; k++) begin
      if (mag[k] > best_mag) begin
        best_mag = mag[k];
        best_pos = POS_W'(k);
      end
    end
    hit = fin && (best_mag >= thresh);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      det_valid <= 1'b0;
      det_pos   <= '0;
      det_peak  <= '0;
    end else begin
      det_valid <= hit;
      if (hit) begin
        det_pos  <= best_pos;
        det_peak <= best_mag;
      end
    end
  end

endmodule

// File: rtl/pn_corr_bank.sv
module pn_corr_bank
  import pncb_pkg::*;
#(
  parameter int NUM_CORR = 8,
  parameter int CODE_LEN = 31,
  parameter int SAMPLE_W = 5,
  localparam int ACC_W = acc_width(SAMPLE_W, CODE_LEN),
  localparam int POS_W = pos_width(NUM_CORR),
  localparam int IDX_W = $clog2(CODE_LEN)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       code_load,
  input  logic [CODE_LEN-1:0]        code_word,
  input  logic                       clear,
  input  logic                       samp_valid,
  input  logic signed [SAMPLE_W-1:0] samp_data,
  input  logic [ACC_W-1:0]           thresh,
  output logic                       det_valid,
  output logic [POS_W-1:0]           det_pos,
  output logic [ACC_W-1:0]           det_peak
);

  logic [CODE_LEN-1:0]        code_q;
  logic                       stg_valid;
  logic signed [SAMPLE_W-1:0] stg_data;
  logic [IDX_W-1:0]           stg_idx;
  logic                       stg_first;
  logic                       stg_last;
  logic [NUM_CORR*ACC_W-1:0]  acc_flat;
  logic                       fin_q;

  pncb_ingest #(
    .CODE_LEN (CODE_LEN),
    .SAMPLE_W (SAMPLE_W)
  ) u_ingest (
    .clk        (clk),
    .rst        (rst),
    .clear      (clear),
    .code_load  (code_load),
    .code_word  (code_word),
    .samp_valid (samp_valid),
    .samp_data  (samp_data),
    .code_q     (code_q),
    .stg_valid  (stg_valid),
    .stg_data   (stg_data),
    .stg_idx    (stg_idx),
    .stg_first  (stg_first),
    .stg_last   (stg_last)
  );

  for (genvar g = 0; g < NUM_CORR; g++) begin : g_lane
    logic signed [ACC_W-1:0] lane_acc;
    pncb_lane #(
      .CODE_LEN (CODE_LEN),
      .SAMPLE_W (SAMPLE_W),
      .ACC_W    (ACC_W),
      .OFFSET   (g)
    ) u_lane (
      .clk    (clk),
      .rst    (rst),
      .en     (stg_valid),
      .first  (stg_first),
      .idx    (stg_idx),
      .code   (code_q),
      .sample (stg_data),
      .acc    (lane_acc)
    );
    assign acc_flat[g*ACC_W +: ACC_W] = lane_acc;
  end

  // Period complete: sums are final in the cycle after the last sample is summed.
  always_ff @(posedge clk) begin
    if (rst) fin_q <= 1'b0;
    else     fin_q <= stg_valid & stg_last & ~(clear | code_load);
  end

  pncb_peak #(
    .NUM_CORR (NUM_CORR),
    .ACC_W    (ACC_W),
    .POS_W    (POS_W)
  ) u_peak (
    .clk       (clk),
    .rst       (rst),
    .fin       (fin_q),
    .thresh    (thresh),
    .acc_flat  (acc_flat),
    .det_valid (det_valid),
    .det_pos   (det_pos),
    .det_peak  (det_peak)
  );

endmodule

// File: rtl/pncb_chk.sv
module pncb_chk #(
  parameter int NUM_CORR = 8,
  parameter int ACC_W    = 10,
  parameter int POS_W    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             clear,
  input logic             code_load,
  input logic             samp_valid,
  input logic [ACC_W-1:0] thresh,
  input logic             det_valid,
  input logic [POS_W-1:0] det_pos,
  input logic [ACC_W-1:0] det_peak
);

  AST_DET_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    det_valid |=> !det_valid); // R5

  AST_DET_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    det_valid |-> $past(samp_valid, 3)); // R5

  AST_PEAK_ABOVE_THRESH: assert property (@(posedge clk) disable iff (rst)
    det_valid |-> (det_peak >= $past(thresh))); // R7

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !det_valid |-> ($stable(det_pos) && $stable(det_peak))); // R8

  AST_POS_IN_BANK: assert property (@(posedge clk) disable iff (rst)
    int'(det_pos) < NUM_CORR); // R6

  AST_RESTART_KILLS: assert property (@(posedge clk) disable iff (rst)
    (clear || code_load) |-> ##2 !det_valid); // R9

endmodule

bind pn_corr_bank pncb_chk #(
  .NUM_CORR (NUM_CORR),
  .ACC_W    (ACC_W),
  .POS_W    (POS_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clear      (clear),
  .code_load  (code_load),
  .samp_valid (samp_valid),
  .thresh     (thresh),
  .det_valid  (det_valid),
  .det_pos    (det_pos),
  .det_peak   (det_peak)
);

// File: tb/pn_corr_bank_test.sv
module pn_corr_bank_test;
  localparam int NC = 8;
  localparam int CL = 31;
  localparam int SW = 5;
  localparam int AW = SW + $clog2(CL);
  localparam int PW = $clog2(NC);

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 code_load = 1'b0;
  logic [CL-1:0]        code_word = '0;
  logic                 clear = 1'b0;
  logic                 samp_valid = 1'b0;
  logic signed [SW-1:0] samp_data = '0;
  logic [AW-1:0]        thresh = '0;
  logic                 det_valid;
  logic [PW-1:0]        det_pos;
  logic [AW-1:0]        det_peak;

  always #2 clk = ~clk;

  pn_corr_bank #(.NUM_CORR(NC), .CODE_LEN(CL), .SAMPLE_W(SW)) uut (
    .clk(clk), .rst(rst), .code_load(code_load), .code_word(code_word),
    .clear(clear), .samp_valid(samp_valid), .samp_data(samp_data),
    .thresh(thresh), .det_valid(det_valid), .det_pos(det_pos), .det_peak(det_peak)
  );

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  // Reference model state
  logic [CL-1:0] code_m = '0;
  int q[$];
  bit exp_v[3];
  int exp_pos[3];
  int exp_peak[3];
  int last_pos = 0;
  int last_peak = 0;
  bit done = 0;

  task automatic compare_now();
    checks++;
    if (exp_v[0]) begin
      if (!det_valid || int'(det_pos) != exp_pos[0] || int'(det_peak) != exp_peak[0]) begin
        fails++;
        $display("FAIL %s: det v=%0d pos=%0d peak=%0d, expected v=1 pos=%0d peak=%0d",
                 cur_req, det_valid, det_pos, det_peak, exp_pos[0], exp_peak[0]);
      end
      last_pos  = exp_pos[0];
      last_peak = exp_peak[0];
    end else if (det_valid || int'(det_pos) != last_pos || int'(det_peak) != last_peak) begin
      fails++;
      $display("FAIL %s: det v=%0d pos=%0d peak=%0d, expected v=0 pos=%0d peak=%0d",
               cur_req, det_valid, det_pos, det_peak, last_pos, last_peak);
    end
  endtask

  task automatic model_period();
    int best = -1;
    int bpos = 0;
    for (int k = 0; k < NC; k++) begin
      int s = 0;
      for (int n = 0; n < CL; n++) begin
        if (code_m[(n + k) % CL]) s += q[n];
        else                      s -= q[n];
      end
      if (s < 0) s = -s;
      if (s > best) begin
        best = s;
        bpos = k;
      end
    end
    exp_v[2]    = (best >= int'(thresh));
    exp_pos[2]  = bpos;
    exp_peak[2] = best;
    q.delete();
  endtask

  task automatic step(input bit v, input int d, input bit clr, input bit ld,
                      input logic [CL-1:0] cw);
    @(negedge clk);
    if (done) return;
    compare_now();
    exp_v[0] = exp_v[1]; exp_pos[0] = exp_pos[1]; exp_peak[0] = exp_peak[1];
    exp_v[1] = exp_v[2]; exp_pos[1] = exp_pos[2]; exp_peak[1] = exp_peak[2];
    exp_v[2] = 1'b0;
    samp_valid = v;
    samp_data  = SW'(d);
    clear      = clr;
    code_load  = ld;
    code_word  = cw;
    if (clr || ld) begin
      exp_v[1] = 1'b0;
      q.delete();
      if (ld) code_m = cw;
    end else if (v) begin
      q.push_back(d);
      if (q.size() == CL) model_period();
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, '0);
  endtask

  task automatic load_code(input logic [CL-1:0] cw);
    step(0, 0, 0, 1, cw);
  endtask

  // Samples matched to the code at offset off, amplitude amp; gap>0 inserts junk idle cycles.
  task automatic aligned(input int count, input int off, input int amp, input int gap);
    for (int n = 0; n < count; n++) begin
      step(1, code_m[(n + off) % CL] ? amp : -amp, 0, 0, '0);
      for (int g = 0; g < gap; g++) step(0, -16, 0, 0, '0);
    end
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin exp_v[i] = 0; exp_pos[i] = 0; exp_peak[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    checks++;
    if (det_valid || det_pos != 0 || det_peak != 0) begin
      fails++;
      $display("FAIL R1: v=%0d pos=%0d peak=%0d, expected 0 0 0", det_valid, det_pos, det_peak);
    end
    idle(2);

    // R2 R3 R5: matched stream at offset 3
    cur_req = "R3";
    thresh = '0;
    load_code(31'h4B3A91E5);
    aligned(CL, 3, 15, 0);
    idle(5);

    // R6: all-zero stream, every sum ties at 0
    cur_req = "R6";
    aligned(CL, 0, 0, 0);
    idle(5);

    // R7 R8: threshold above any reachable peak; outputs must hold
    cur_req = "R7";
    thresh = AW'(500);
    aligned(CL, 4, 15, 0);
    idle(5);
    thresh = '0;
    idle(1);

    // R4: gaps carrying junk data
    cur_req = "R4";
    aligned(CL, 6, 11, 1);
    idle(5);

    // R9: clear in mid-period, then a full period
    cur_req = "R9";
    aligned(10, 2, 9, 0);
    step(1, 15, 1, 0, '0);
    aligned(CL, 1, 13, 0);
    idle(5);

    // R10: code load mid-period, then a period matched to the new code
    cur_req = "R10";
    aligned(12, 0, 7, 0);
    load_code(31'h1D5C_2E67);
    aligned(CL, 5, 14, 0);
    idle(5);

    // R11: two periods back to back
    cur_req = "R11";
    aligned(CL, 2, 12, 0);
    aligned(CL, 7, 10, 0);
    idle(5);

    // R12 and R7 boundary: extreme sums, peak equal to threshold
    cur_req = "R12";
    load_code({CL{1'b1}});
    thresh = AW'(496);
    for (int n = 0; n < CL; n++) step(1, -16, 0, 0, '0);
    idle(5);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule